// File: doc/BRIEF.md
# Serial Port Enable and Configuration-Lock Controller

This block is the control front end of a synchronous serial port. It keeps one control register, one clock divisor and one frame-sync divisor for each direction (transmit and receive), a shared channel-select word, and a status word. A direction is switched on and off through the enable bit in its control register. While a direction runs, its configuration is frozen. The block produces the serial clock, tracks start-up after enable, issues internally timed frame syncs or samples external ones, and aborts all of that direction's activity when it is switched off.

Software reaches the block through a one-cycle write strobe and a combinational read port that share a 3-bit register select. The serial clock comes either from the system clock through the divisor or from an external serial clock pin, chosen per direction. In multichannel operation the block enforces the shutdown order: transmit goes off first, then receive, and transmit cannot return until receive has also gone off. Each rejected request raises a sticky error bit.

Top module: `serport_ctrl`

## Requirements
- R1: After reset every register reads zero at all eight selects, and the serial clock, frame sync and ready outputs of both directions are low.
- R2: Select 0 is the transmit control and select 1 the receive control, 8 bits each: bit 0 enable, bit 1 internal clock, bit 2 internal frame sync, bit 3 multichannel (taken from the receive register), bits 7:4 word length. While a direction is enabled, a write to its control register changes only bit 0. Bits 7:1 keep their value and stay readable, and a write that tries to change them sets the error bit.
- R3: Selects 4 and 5 are the transmit and receive frame-sync divisors. A write to one of them while its direction is enabled is ignored and sets the error bit. The clock divisors (selects 2 and 3) and the channel-select word (select 6) accept writes at any time, with no error.
- R4: With the internal clock, the serial clock output first rises D system clocks after the enabling write edge, where D = divisor+1, and then toggles every D cycles.
- R5: The ready output rises on the same edge as the second serial clock rising edge after enable, so within three serial clocks of enable.
- R6: With internal frame sync and frame-sync divisor F, the frame sync output first rises at the (F+1)th serial clock rise after ready. It stays high for one serial clock period and repeats every F+1 serial clocks.
- R7: With external frame sync, the frame sync input is sampled only on serial clock rises while ready. A sampled high sets the direction's frame-seen status bit (select 7: bit 0 transmit, bit 1 receive). A high seen before ready has no effect.
- R8: Clearing a direction's enable bit drops its ready, serial clock and frame sync outputs and its frame-seen bit in the next cycle.
- R9: With the multichannel bit set, a request to disable receive while transmit is enabled is refused. Disabling transmit while receive runs sets the draining bit (status bit 3), and a transmit enable during draining is refused. Draining ends when receive is disabled. Each refusal sets the error bit.
- R10: Status bit 2 is the sticky error bit. It stays set until a write to select 7 with bit 2 high.
- R11: With the external clock, serial clock rises are the rising edges of the external clock input after a two-stage synchronizer, and the serial clock output stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 3 | Register select for reads and writes |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the selected register, combinational |
| ext_sclk_i | input | 1 | External serial clock, asynchronous |
| tx_fs_i | input | 1 | External transmit frame sync |
| rx_fs_i | input | 1 | External receive frame sync |
| tx_sclk_o | output | 1 | Internally generated transmit serial clock |
| rx_sclk_o | output | 1 | Internally generated receive serial clock |
| tx_fs_o | output | 1 | Internally generated transmit frame sync |
| rx_fs_o | output | 1 | Internally generated receive frame sync |
| tx_ready_o | output | 1 | Transmit direction ready after start-up |
| rx_ready_o | output | 1 | Receive direction ready after start-up |

## Verification
Some invariants are checked by assertions on every cycle: a locked frame-sync divisor and locked control bits never change while their direction runs; a disabled direction holds no ready, frame or seen state; a frame sync never appears before ready; draining only exists with receive on and transmit off; receive never goes off alone under multichannel; and the error bit never clears without its clear write. Other behaviour can only be shown by the bench scenarios. These cover the exact edges of the first serial clock rise, the ready point, the first and second frame syncs and the pulse width. They also cover the refusal and recovery sequence of the multichannel ordering, external frame syncs being ignored before ready, and the exemption of the clock divisor from the lock.

// File: rtl/serport_pkg.sv
`timescale 1ns/1ps
package serport_pkg;

  localparam int ADDR_W = 3;
  localparam int CTL_W  = 8;

  // control register bit positions
  localparam int CTL_EN   = 0;
  localparam int CTL_ICLK = 1;
  localparam int CTL_IFS  = 2;
  localparam int CTL_MC   = 3;

  // status register bit positions
  localparam int ST_TX_SEEN = 0;
  localparam int ST_RX_SEEN = 1;
  localparam int ST_ERR     = 2;
  localparam int ST_DRAIN   = 3;

  // register selects
  localparam logic [ADDR_W-1:0] SEL_TXCTL = 3'd0;
  localparam logic [ADDR_W-1:0] SEL_RXCTL = 3'd1;
  localparam logic [ADDR_W-1:0] SEL_TXCKD = 3'd2;
  localparam logic [ADDR_W-1:0] SEL_RXCKD = 3'd3;
  localparam logic [ADDR_W-1:0] SEL_TXFSD = 3'd4;
  localparam logic [ADDR_W-1:0] SEL_RXFSD = 3'd5;
  localparam logic [ADDR_W-1:0] SEL_CHSEL = 3'd6;
  localparam logic [ADDR_W-1:0] SEL_STAT  = 3'd7;

  // true when a write would alter any configuration bit above the enable
  function automatic logic cfg_changed(input logic [CTL_W-1:0] cur,
                                       input logic [CTL_W-1:0] req);
    return cur[CTL_W-1:1] != req[CTL_W-1:1];
  endfunction

  // merge of a control write: while running only the enable bit moves
  function automatic logic [CTL_W-1:0] ctl_merge(input logic [CTL_W-1:0] cur,
                                                 input logic [CTL_W-1:0] req,
                                                 input logic             en_next);
    logic [CTL_W-1:0] r;
    r = cur[CTL_EN] ? cur : req;
    r[CTL_EN] = en_next;
    return r;
  endfunction

  // counter wrap test used by the divisors (tolerates a shrinking limit)
  function automatic logic wrap_hit(input logic [15:0] cnt, input logic [15:0] lim);
    return cnt >= lim;
  endfunction

endpackage

// File: rtl/serport_sync.sv
`timescale 1ns/1ps
module serport_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/serport_regs.sv
`timescale 1ns/1ps
module serport_regs
  import serport_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int DIV_W   = 8,
  parameter int FSDIV_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic [1:0]          seen_i,
  output logic [CTL_W-1:0]    tx_ctl_o,
  output logic [CTL_W-1:0]    rx_ctl_o,
  output logic [DIV_W-1:0]    tx_ckd_o,
  output logic [DIV_W-1:0]    rx_ckd_o,
  output logic [FSDIV_W-1:0]  tx_fsd_o,
  output logic [FSDIV_W-1:0]  rx_fsd_o,
  output logic [DATA_W-1:0]   rdata_o
);
  logic [CTL_W-1:0]   tx_ctl_q, rx_ctl_q;
  logic [DIV_W-1:0]   tx_ckd_q, rx_ckd_q;
  logic [FSDIV_W-1:0] tx_fsd_q, rx_fsd_q;
  logic [DATA_W-1:0]  chsel_q;
  logic               err_q, drain_q;

  // decoded write events, brought out as named wires
  logic wr_txctl, wr_rxctl, wr_txfsd, wr_rxfsd, wr_stat_clr;
  logic [CTL_W-1:0] req_ctl;
  logic mc_mode;
  logic tx_cfg_viol, rx_cfg_viol, tx_fsd_viol, rx_fsd_viol;
  logic tx_on_refused, rx_off_refused, drain_enter, drain_leave;
  logic tx_en_next, rx_en_next, any_viol;

  assign req_ctl     = wdata_i[CTL_W-1:0];
  assign wr_txctl    = wr_i && (addr_i == SEL_TXCTL);
  assign wr_rxctl    = wr_i && (addr_i == SEL_RXCTL);
  assign wr_txfsd    = wr_i && (addr_i == SEL_TXFSD);
  assign wr_rxfsd    = wr_i && (addr_i == SEL_RXFSD);
  assign wr_stat_clr = wr_i && (addr_i == SEL_STAT) && wdata_i[ST_ERR];
  assign mc_mode     = rx_ctl_q[CTL_MC];

  assign tx_cfg_viol = wr_txctl && tx_ctl_q[CTL_EN] && cfg_changed(tx_ctl_q, req_ctl);
  assign rx_cfg_viol = wr_rxctl && rx_ctl_q[CTL_EN] && cfg_changed(rx_ctl_q, req_ctl);
  assign tx_fsd_viol = wr_txfsd && tx_ctl_q[CTL_EN];
  assign rx_fsd_viol = wr_rxfsd && rx_ctl_q[CTL_EN];

  // multichannel ordering
  assign rx_off_refused = wr_rxctl && mc_mode && rx_ctl_q[CTL_EN] &&
                          !req_ctl[CTL_EN] && tx_ctl_q[CTL_EN];
  assign tx_on_refused  = wr_txctl && mc_mode && drain_q &&
                          !tx_ctl_q[CTL_EN] && req_ctl[CTL_EN];
  assign drain_enter    = wr_txctl && mc_mode && tx_ctl_q[CTL_EN] &&
                          !req_ctl[CTL_EN] && rx_ctl_q[CTL_EN];
  assign drain_leave    = !rx_ctl_q[CTL_EN] ||
                          (wr_rxctl && !req_ctl[CTL_EN] && !rx_off_refused);

  assign tx_en_next = req_ctl[CTL_EN] && !tx_on_refused;
  assign rx_en_next = req_ctl[CTL_EN] || rx_off_refused;
  assign any_viol   = tx_cfg_viol || rx_cfg_viol || tx_fsd_viol || rx_fsd_viol ||
                      tx_on_refused || rx_off_refused;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_ctl_q <= '0;
      rx_ctl_q <= '0;
      tx_ckd_q <= '0;
      rx_ckd_q <= '0;
      tx_fsd_q <= '0;
      rx_fsd_q <= '0;
      chsel_q  <= '0;
      err_q    <= 1'b0;
      drain_q  <= 1'b0;
    end else begin
      if (wr_txctl) tx_ctl_q <= ctl_merge(tx_ctl_q, req_ctl, tx_en_next);
      if (wr_rxctl) rx_ctl_q <= ctl_merge(rx_ctl_q, req_ctl, rx_en_next);
      if (wr_i && addr_i == SEL_TXCKD) tx_ckd_q <= wdata_i[DIV_W-1:0];
      if (wr_i && addr_i == SEL_RXCKD) rx_ckd_q <= wdata_i[DIV_W-1:0];
      if (wr_txfsd && !tx_fsd_viol) tx_fsd_q <= wdata_i[FSDIV_W-1:0];
      if (wr_rxfsd && !rx_fsd_viol) rx_fsd_q <= wdata_i[FSDIV_W-1:0];
      if (wr_i && addr_i == SEL_CHSEL) chsel_q <= wdata_i;
      if (any_viol)         err_q <= 1'b1;
      else if (wr_stat_clr) err_q <= 1'b0;
      if (drain_enter)      drain_q <= 1'b1;
      else if (drain_leave) drain_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      SEL_TXCTL: rdata_o = DATA_W'(tx_ctl_q);
      SEL_RXCTL: rdata_o = DATA_W'(rx_ctl_q);
      SEL_TXCKD: rdata_o = DATA_W'(tx_ckd_q);
      SEL_RXCKD: rdata_o = DATA_W'(rx_ckd_q);
      SEL_TXFSD: rdata_o = DATA_W'(tx_fsd_q);
      SEL_RXFSD: rdata_o = DATA_W'(rx_fsd_q);
      SEL_CHSEL: rdata_o = chsel_q;
      default: begin
        rdata_o[ST_TX_SEEN] = seen_i[0];
        rdata_o[ST_RX_SEEN] = seen_i[1];
        rdata_o[ST_ERR]     = err_q;
        rdata_o[ST_DRAIN]   = drain_q;
      end
    endcase
  end

  assign tx_ctl_o = tx_ctl_q;
  assign rx_ctl_o = rx_ctl_q;
  assign tx_ckd_o = tx_ckd_q;
  assign rx_ckd_o = rx_ckd_q;
  assign tx_fsd_o = tx_fsd_q;
  assign rx_fsd_o = rx_fsd_q;

  // R3: frame-sync divisors are frozen while their direction runs
  assert_tx_fsd_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ctl_q[CTL_EN] |=> $stable(tx_fsd_q));
  assert_rx_fsd_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ctl_q[CTL_EN] |=> $stable(rx_fsd_q));
  // R2: configuration bits above the enable hold while running
  assert_tx_cfg_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ctl_q[CTL_EN] |=> $stable(tx_ctl_q[CTL_W-1:1]));
  assert_rx_cfg_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ctl_q[CTL_EN] |=> $stable(rx_ctl_q[CTL_W-1:1]));
  // R9: draining only with receive on and transmit off
  assert_drain_shape_R9: assert property (@(posedge clk) disable iff (!rst_n)
    drain_q |-> (rx_ctl_q[CTL_EN] && !tx_ctl_q[CTL_EN]));
  // R9: receive never drops alone in multichannel mode
  assert_rx_not_alone_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mc_mode && tx_ctl_q[CTL_EN] && rx_ctl_q[CTL_EN]) |=>
      (rx_ctl_q[CTL_EN] || !tx_ctl_q[CTL_EN]));
  // R10: error bit is sticky
  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !wr_stat_clr) |=> err_q);
endmodule

// File: rtl/serport_dir.sv
`timescale 1ns/1ps
module serport_dir
  import serport_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int FSDIV_W     = 8,
  parameter int START_EDGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_i,
  input  logic               iclk_i,
  input  logic               ifs_i,
  input  logic [DIV_W-1:0]   ckd_i,
  input  logic [FSDIV_W-1:0] fsd_i,
  input  logic               ext_tick_i,
  input  logic               ext_fs_i,
  output logic               sclk_o,
  output logic               fs_o,
  output logic               ready_o,
  output logic               seen_o
);
  localparam int SW = $clog2(START_EDGES + 1);

  logic [DIV_W-1:0]   div_cnt_q;
  logic               phase_q;
  logic [SW-1:0]      start_q;
  logic               ready_q;
  logic [FSDIV_W-1:0] fs_cnt_q;
  logic               fs_q;
  logic               seen_q;

  // named internal events
  logic half_wrap, rise_tick, start_done, fs_event, ext_fs_event;

  assign half_wrap    = wrap_hit(16'(div_cnt_q), 16'(ckd_i));
  assign rise_tick    = en_i && (iclk_i ? (half_wrap && !phase_q) : ext_tick_i);
  assign start_done   = rise_tick && !ready_q && (start_q == SW'(START_EDGES - 1));
  assign fs_event     = rise_tick && ready_q && ifs_i &&
                        wrap_hit(16'(fs_cnt_q), 16'(fsd_i));
  assign ext_fs_event = rise_tick && ready_q && !ifs_i && ext_fs_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt_q <= '0;
      phase_q   <= 1'b0;
      start_q   <= '0;
      ready_q   <= 1'b0;
      fs_cnt_q  <= '0;
      fs_q      <= 1'b0;
      seen_q    <= 1'b0;
    end else if (!en_i) begin
      div_cnt_q <= '0;
      phase_q   <= 1'b0;
      start_q   <= '0;
      ready_q   <= 1'b0;
      fs_cnt_q  <= '0;
      fs_q      <= 1'b0;
      seen_q    <= 1'b0;
    end else begin
      if (iclk_i) begin
        if (half_wrap) begin
          div_cnt_q <= '0;
          phase_q   <= !phase_q;
        end else begin
          div_cnt_q <= div_cnt_q + 1'b1;
        end
      end
      if (rise_tick && !ready_q) begin
        if (start_done) begin
          ready_q <= 1'b1;
          start_q <= '0;
        end else begin
          start_q <= start_q + 1'b1;
        end
      end
      if (rise_tick && ready_q && ifs_i) begin
        fs_cnt_q <= fs_event ? '0 : fs_cnt_q + 1'b1;
        fs_q     <= fs_event;
      end
      if (fs_event || ext_fs_event) seen_q <= 1'b1;
    end
  end

  assign sclk_o  = phase_q && en_i && iclk_i;
  assign fs_o    = fs_q && en_i && ifs_i;
  assign ready_o = ready_q && en_i;
  assign seen_o  = seen_q && en_i;

  // R8: disabling clears all run state by the next cycle
  assert_abort_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (!ready_q && !fs_q && !seen_q && !phase_q));
  // R6: no frame sync before ready
  assert_fs_after_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fs_q |-> ready_q);
  // R5: ready only rises on a serial clock rise
  assert_ready_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready_q && en_i && !rise_tick) |=> !ready_q);
endmodule

// File: rtl/serport_ctrl.sv
`timescale 1ns/1ps
module serport_ctrl
  import serport_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int DIV_W       = 8,
  parameter int FSDIV_W     = 8,
  parameter int SYNC_STAGES = 2,
  parameter int START_EDGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ext_sclk_i,
  input  logic              tx_fs_i,
  input  logic              rx_fs_i,
  output logic              tx_sclk_o,
  output logic              rx_sclk_o,
  output logic              tx_fs_o,
  output logic              rx_fs_o,
  output logic              tx_ready_o,
  output logic              rx_ready_o
);
  localparam int NDIR = 2;

  logic [CTL_W-1:0]   tx_ctl, rx_ctl;
  logic [DIV_W-1:0]   tx_ckd, rx_ckd;
  logic [FSDIV_W-1:0] tx_fsd, rx_fsd;
  logic [NDIR-1:0]    seen_v, sclk_v, fs_v, ready_v, ext_fs_v;
  logic [CTL_W-1:0]   ctl_a   [NDIR];
  logic [DIV_W-1:0]   ckd_a   [NDIR];
  logic [FSDIV_W-1:0] fsd_a   [NDIR];
  logic               sclk_s, sclk_prev_q, ext_tick;
  logic               tx_fs_s, rx_fs_s;

  serport_regs #(.DATA_W(DATA_W), .DIV_W(DIV_W), .FSDIV_W(FSDIV_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_i(bus_wr), .addr_i(bus_addr), .wdata_i(bus_wdata),
    .seen_i(seen_v), .tx_ctl_o(tx_ctl), .rx_ctl_o(rx_ctl), .tx_ckd_o(tx_ckd),
    .rx_ckd_o(rx_ckd), .tx_fsd_o(tx_fsd), .rx_fsd_o(rx_fsd), .rdata_o(bus_rdata)
  );

  serport_sync #(.STAGES(SYNC_STAGES)) u_sync_sclk (
    .clk(clk), .rst_n(rst_n), .d_i(ext_sclk_i), .q_o(sclk_s));
  serport_sync #(.STAGES(SYNC_STAGES)) u_sync_txfs (
    .clk(clk), .rst_n(rst_n), .d_i(tx_fs_i), .q_o(tx_fs_s));
  serport_sync #(.STAGES(SYNC_STAGES)) u_sync_rxfs (
    .clk(clk), .rst_n(rst_n), .d_i(rx_fs_i), .q_o(rx_fs_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_prev_q <= 1'b0;
    else        sclk_prev_q <= sclk_s;
  end
  assign ext_tick = sclk_s && !sclk_prev_q;

  assign ctl_a[0] = tx_ctl;
  assign ctl_a[1] = rx_ctl;
  assign ckd_a[0] = tx_ckd;
  assign ckd_a[1] = rx_ckd;
  assign fsd_a[0] = tx_fsd;
  assign fsd_a[1] = rx_fsd;
  assign ext_fs_v = {rx_fs_s, tx_fs_s};

  for (genvar g = 0; g < NDIR; g++) begin : g_dir
    serport_dir #(.DIV_W(DIV_W), .FSDIV_W(FSDIV_W), .START_EDGES(START_EDGES)) u_dir (
      .clk(clk), .rst_n(rst_n),
      .en_i(ctl_a[g][CTL_EN]), .iclk_i(ctl_a[g][CTL_ICLK]), .ifs_i(ctl_a[g][CTL_IFS]),
      .ckd_i(ckd_a[g]), .fsd_i(fsd_a[g]),
      .ext_tick_i(ext_tick), .ext_fs_i(ext_fs_v[g]),
      .sclk_o(sclk_v[g]), .fs_o(fs_v[g]), .ready_o(ready_v[g]), .seen_o(seen_v[g])
    );
  end

  assign tx_sclk_o  = sclk_v[0];
  assign rx_sclk_o  = sclk_v[1];
  assign tx_fs_o    = fs_v[0];
  assign rx_fs_o    = fs_v[1];
  assign tx_ready_o = ready_v[0];
  assign rx_ready_o = ready_v[1];
endmodule

// File: tb/serport_ctrl_tb.sv
`timescale 1ns/1ps
module serport_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        ext_sclk_i = 1'b0, tx_fs_i = 1'b0, rx_fs_i = 1'b0;
  logic        tx_sclk_o, rx_sclk_o, tx_fs_o, rx_fs_o, tx_ready_o, rx_ready_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;
  int exp_fs_q[$];
  int exp_width = 0;
  int last_rise = 0;
  bit prev_fs = 0;

  always #10 clk = ~clk;   // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  serport_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_sclk_i(ext_sclk_i),
    .tx_fs_i(tx_fs_i), .rx_fs_i(rx_fs_i), .tx_sclk_o(tx_sclk_o), .rx_sclk_o(rx_sclk_o),
    .tx_fs_o(tx_fs_o), .rx_fs_o(rx_fs_o), .tx_ready_o(tx_ready_o), .rx_ready_o(rx_ready_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input int exp, input string tag);
    @(negedge clk);
    bus_addr = a;
    #1 chk(tag, int'(bus_rdata), exp);
  endtask

  task automatic wait_cyc(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic ext_pulse();
    @(negedge clk); ext_sclk_i = 1'b1;
    repeat (5) @(negedge clk);
    ext_sclk_i = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  // scoreboard monitor for transmit frame syncs (R6)
  always @(negedge clk) begin
    if (rst_n) begin
      if (tx_fs_o && !prev_fs) begin
        if (exp_fs_q.size() == 0) chk("R6 unexpected frame sync", 1, 0);
        else chk("R6 frame sync rise cycle", cyc, exp_fs_q.pop_front());
        last_rise = cyc;
      end
      if (!tx_fs_o && prev_fs && exp_width != 0)
        chk("R6 frame sync width", cyc - last_rise, exp_width);
      prev_fs = tx_fs_o;
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int idx;
    int d, f;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 8; a++) rd_chk(3'(a), 0, "R1 register reset value");
    chk("R1 outputs low", int'({tx_sclk_o, rx_sclk_o, tx_fs_o, rx_fs_o, tx_ready_o, rx_ready_o}), 0);

    // transmit, internal clock and frame sync: D = 2, F = 2
    d = 2; f = 2;
    wr(3'd2, 16'd1);
    wr(3'd4, 16'd2);
    wr(3'd0, 16'h0057);
    idx = cyc;
    exp_width = 2 * d;
    exp_fs_q.push_back(idx + (5 + 2 * f) * d);
    exp_fs_q.push_back(idx + (5 + 2 * f) * d + 2 * (f + 1) * d);
    wait_cyc(idx + d - 1); chk("R4 sclk low before first rise", int'(tx_sclk_o), 0);
    wait_cyc(idx + d);     chk("R4 sclk first rise", int'(tx_sclk_o), 1);
    wait_cyc(idx + 2 * d); chk("R4 sclk falls after D", int'(tx_sclk_o), 0);
    wait_cyc(idx + 3 * d - 1); chk("R5 not ready before second rise", int'(tx_ready_o), 0);
    wait_cyc(idx + 3 * d); chk("R5 ready at second rise", int'(tx_ready_o), 1);

    // R3 locked frame-sync divisor
    wr(3'd4, 16'd9);
    rd_chk(3'd4, 2, "R3 locked fsdiv unchanged");
    rd_chk(3'd7, 4, "R3 lock violation sets error");
    // R2 config bits hold while running
    wr(3'd0, 16'h0007);
    rd_chk(3'd0, 16'h0057, "R2 config bits kept while enabled");
    wr(3'd7, 16'h0004);
    rd_chk(3'd7, 0, "R10 error cleared by write one");

    while (exp_fs_q.size() != 0) @(negedge clk);
    wait_cyc(idx + 36);
    exp_width = 0;
    rd_chk(3'd7, 1, "R6 transmit frame seen");
    wr(3'd0, 16'h0056);
    chk("R8 ready dropped", int'(tx_ready_o), 0);
    chk("R8 sclk dropped", int'(tx_sclk_o), 0);
    chk("R8 frame sync dropped", int'(tx_fs_o), 0);
    rd_chk(3'd7, 0, "R8 status cleared on disable");
    rd_chk(3'd0, 16'h0056, "R2 config readable after disable");

    // receive, external clock and frame sync (R11, R7)
    rx_fs_i = 1'b1;
    wr(3'd1, 16'h0001);
    ext_pulse();
    chk("R11 not ready after one external rise", int'(rx_ready_o), 0);
    chk("R11 sclk output stays low", int'(rx_sclk_o), 0);
    ext_pulse();
    chk("R11 ready after two external rises", int'(rx_ready_o), 1);
    rd_chk(3'd7, 0, "R7 frame sync before ready ignored");
    ext_pulse();
    rd_chk(3'd7, 2, "R7 external frame sync seen when ready");
    wr(3'd1, 16'h0000);
    chk("R8 receive ready dropped", int'(rx_ready_o), 0);
    rd_chk(3'd7, 0, "R8 receive seen cleared");
    rx_fs_i = 1'b0;

    // multichannel ordering (R9) and exempt clock divisor (R3)
    wr(3'd0, 16'h0003);
    wr(3'd1, 16'h0009);
    wr(3'd2, 16'd3);
    rd_chk(3'd2, 3, "R3 clock divisor writable while enabled");
    wr(3'd6, 16'hA5C3);
    rd_chk(3'd6, 16'hA5C3, "R3 channel select writable while enabled");
    rd_chk(3'd7, 0, "R3 exempt writes raise no error");
    wr(3'd1, 16'h0008);
    rd_chk(3'd1, 16'h0009, "R9 receive-only disable refused");
    rd_chk(3'd7, 4, "R9 refusal sets error");
    wr(3'd7, 16'h0004);
    wr(3'd0, 16'h0002);
    rd_chk(3'd0, 16'h0002, "R9 transmit disable accepted");
    rd_chk(3'd7, 8, "R9 draining entered");
    wr(3'd0, 16'h0003);
    rd_chk(3'd0, 16'h0002, "R9 transmit re-enable refused while draining");
    rd_chk(3'd7, 16'h000C, "R9 refused re-enable sets error");
    wr(3'd1, 16'h0008);
    rd_chk(3'd1, 16'h0008, "R9 receive disable after transmit");
    rd_chk(3'd7, 4, "R10 error sticky after draining ends");
    wr(3'd0, 16'h0003);
    rd_chk(3'd0, 16'h0003, "R9 re-enable allowed after both off");
    wr(3'd7, 16'h0004);
    rd_chk(3'd7, 0, "R10 error cleared");
    wr(3'd0, 16'h0002);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule